// File: doc/BRIEF.md
# Selectable Reference Clock Divider Chain

This block turns a free-running crystal reference clock into two slow timing strobes. One is the phase-comparison strobe for a channel-select PLL. The other is a demodulator strobe taken from partway along the same chain. Five selection bits choose one ratio in each of several cascaded counter stages. With them, either of two common crystal frequencies can be brought down to a 10, 12.5, 20 or 25 kHz comparison rate. A final stage can divide by up to four more, which leaves room for a frequency multiplier placed off the block.

Every stage is clocked by the reference clock itself and advances only on a clock enable. Each output is a single-cycle pulse, and any logic clocked from the same reference can consume it directly. A change to the selection restarts the whole chain from zero, so the first period after a change is always complete. The chain must keep running whenever the demodulator is active, because the demodulator strobe comes from it.

Top module: `refclk_div_chain`

## Requirements
- R1: While `rstN` is low both outputs are low and every stage counter is zero. If `enable` is held high from release with `rdSel` = 0, the first `cmpPulse` follows the 512th enabled clock edge.
- R2: The `cmpPulse` period in clock cycles is 8 × A × B × C × D. A is 9 when `rdSel[0]` is 1 and 8 otherwise. B is 5 when `rdSel[1]` is 1 and 4 otherwise. C is 4 when `rdSel[2]` is 1 and 2 otherwise. D is set as in R4.
- R3: The `demodPulse` period is 8 × A cycles, which is 64 or 72 depending only on `rdSel[0]`.
- R4: The last-stage ratio D comes from `rdSel[3]` and `rdSel[4]`: both 0 gives 1 (bypass), `rdSel[4]`=1 alone gives 2, `rdSel[3]`=1 alone gives 3, and both 1 gives 4.
- R5: A clock edge that samples a `rdSel` value different from the one sampled at the previous edge clears every stage counter and emits no pulse. The next `cmpPulse` then follows exactly N further enabled edges, where N is the new total ratio.
- R6: While `enable` is low, no stage advances and neither output pulses. Counting resumes from the held state once `enable` returns high.
- R7: Each pulse lasts exactly one clock cycle, and every `cmpPulse` coincides with a `demodPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Chain runs when high |
| rdSel | input | 5 | Ratio selection bits (bit0..bit4 as in R2 and R4) |
| cmpPulse | output | 1 | Comparison strobe, one cycle per period |
| demodPulse | output | 1 | Demodulator strobe from the second stage |

## Verification
Each output is registered once. A pulse is therefore visible in the cycle right after the enabled edge that completes its count: N cycles after counting starts for `cmpPulse`, and 8 × A cycles for `demodPulse`. After a selection change, counting starts one edge later, because the edge that sees the change only clears the counters. A driver computes every expected pulse cycle from these rules, stretched by the number of disabled edges when `enable` is dropped, and queues it. A monitor sampling on the falling edge compares each pulse it sees against the head of the queue. It flags unexpected pulses, late pulses and missing pulses.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int SEL_W      = 5;
  localparam int NUM_STAGES = 5;
  localparam int CNT_W      = 4;
  localparam int DEMOD_TAP  = 1;

  typedef struct packed {
    logic advance;
    logic clear;
  } divStrobe_t;
endpackage

// File: rtl/rdc_stage.sv
module rdc_stage #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          tickIn,
  input  logic [CW-1:0] lastCnt,
  output logic          tickOut
);
  logic [CW-1:0] cnt;
  logic          atLast;

  assign atLast  = (cnt == lastCnt);
  assign tickOut = tickIn & atLast;

  always_ff @(posedge clk) begin
    if (!rstN || clear) cnt <= '0;
    else if (tickIn)    cnt <= atLast ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rdc_ctrl.sv
module rdc_ctrl
  import rdc_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             enable,
  input  logic [SEL_W-1:0]                 rdSel,
  output divStrobe_t                       strobe,
  output logic [NUM_STAGES-1:0][CNT_W-1:0] lastCnt
);
  logic [SEL_W-1:0] selQ;
  logic             selChanged;

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= '0;
    else       selQ <= rdSel;
  end

  assign selChanged     = (rdSel != selQ);
  assign strobe.clear   = selChanged;
  assign strobe.advance = enable & ~selChanged;

  always_comb begin
    lastCnt[0] = CNT_W'(7);
    lastCnt[1] = selQ[0] ? CNT_W'(8) : CNT_W'(7);
    lastCnt[2] = selQ[1] ? CNT_W'(4) : CNT_W'(3);
    lastCnt[3] = selQ[2] ? CNT_W'(3) : CNT_W'(1);
    lastCnt[4] = CNT_W'({selQ[3], selQ[4]});
  end
endmodule

// File: rtl/rdc_datapath.sv
module rdc_datapath
  import rdc_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  divStrobe_t                       strobe,
  input  logic [NUM_STAGES-1:0][CNT_W-1:0] lastCnt,
  output logic                             cmpPulse,
  output logic                             demodPulse
);
  logic [NUM_STAGES:0] tick;

  assign tick[0] = strobe.advance;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    rdc_stage #(.CW(CNT_W)) u_stage (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (strobe.clear),
      .tickIn (tick[i]),
      .lastCnt(lastCnt[i]),
      .tickOut(tick[i+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpPulse   <= 1'b0;
      demodPulse <= 1'b0;
    end else begin
      cmpPulse   <= tick[NUM_STAGES];
      demodPulse <= tick[DEMOD_TAP+1];
    end
  end
endmodule

// File: rtl/refclk_div_chain.sv
module refclk_div_chain
  import rdc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] rdSel,
  output logic             cmpPulse,
  output logic             demodPulse
);
  divStrobe_t                       strobe;
  logic [NUM_STAGES-1:0][CNT_W-1:0] lastCnt;

  rdc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .rdSel  (rdSel),
    .strobe (strobe),
    .lastCnt(lastCnt)
  );

  rdc_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lastCnt   (lastCnt),
    .cmpPulse  (cmpPulse),
    .demodPulse(demodPulse)
  );
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker
  import rdc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [SEL_W-1:0] rdSel,
  input logic             cmpPulse,
  input logic             demodPulse
);
  // R7
  cmp_with_demod_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpPulse |-> demodPulse);

  // R7
  cmp_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpPulse |=> !cmpPulse);

  // R7
  demod_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    demodPulse |=> !demodPulse);

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!cmpPulse && !demodPulse));

  // R5
  restart_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel != $past(rdSel)) |=> (!cmpPulse && !demodPulse));
endmodule

bind refclk_div_chain rdc_checker u_rdc_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .rdSel     (rdSel),
  .cmpPulse  (cmpPulse),
  .demodPulse(demodPulse)
);

// File: tb/refclk_div_chain_tb.sv
module refclk_div_chain_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [4:0] rdSel = 5'd0;
  logic       cmpPulse, demodPulse;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  int    cmpQ[$];
  string cmpTag[$];
  int    demQ[$];
  string demTag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refclk_div_chain u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .rdSel(rdSel),
    .cmpPulse(cmpPulse), .demodPulse(demodPulse)
  );

  function automatic int ratioOf(input logic [4:0] s);
    int a = s[0] ? 9 : 8;
    int b = s[1] ? 5 : 4;
    int c = s[2] ? 4 : 2;
    int d = 1 + int'(s[4]) + 2 * int'(s[3]);
    return 8 * a * b * c * d;
  endfunction

  function automatic int demodOf(input logic [4:0] s);
    return s[0] ? 72 : 64;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver side: queue every expected pulse cycle within the horizon
  task automatic pushRun(input int start, input int n, input int d, input int horizon,
                         input string tag);
    for (int k = n; k <= horizon; k += n) begin
      cmpQ.push_back(start + k);
      cmpTag.push_back(tag);
    end
    for (int k = d; k <= horizon; k += d) begin
      demQ.push_back(start + k);
      demTag.push_back((k % n == 0) ? "R7" : "R3");
    end
  endtask

  task automatic waitTo(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    @(negedge clk);
    chk(cmpQ.size() == 0 && demQ.size() == 0, tag, cmpQ.size() + demQ.size(), 0);
    cmpQ.delete(); cmpTag.delete(); demQ.delete(); demTag.delete();
  endtask

  task automatic runCfg(input logic [4:0] s, input int periods, input string tag);
    int c0, n;
    n = ratioOf(s);
    @(negedge clk);
    c0 = cyc;
    rdSel = s;
    pushRun(c0 + 1, n, demodOf(s), periods * n, tag);
    waitTo(c0 + 1 + periods * n);
    drain(tag);
  endtask

  // Monitor side: compare each observed pulse with the queue head
  always @(negedge clk) begin
    if (rstN && !done) begin
      while (cmpQ.size() > 0 && cmpQ[0] < cyc) begin
        chk(1'b0, {cmpTag[0], " missed cmpPulse"}, cyc, cmpQ[0]);
        void'(cmpQ.pop_front()); void'(cmpTag.pop_front());
      end
      while (demQ.size() > 0 && demQ[0] < cyc) begin
        chk(1'b0, {demTag[0], " missed demodPulse"}, cyc, demQ[0]);
        void'(demQ.pop_front()); void'(demTag.pop_front());
      end
      if (cmpPulse) begin
        if (cmpQ.size() == 0) chk(1'b0, "R2 unexpected cmpPulse", cyc, -1);
        else begin
          chk(cmpQ[0] == cyc, {cmpTag[0], " cmpPulse time"}, cyc, cmpQ[0]);
          void'(cmpQ.pop_front()); void'(cmpTag.pop_front());
        end
      end
      if (demodPulse) begin
        if (demQ.size() == 0) chk(1'b0, "R3 unexpected demodPulse", cyc, -1);
        else begin
          chk(demQ[0] == cyc, {demTag[0], " demodPulse time"}, cyc, demQ[0]);
          void'(demQ.pop_front()); void'(demTag.pop_front());
        end
      end
    end
  end

  initial begin
    int c0, n, m, h;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!cmpPulse && !demodPulse, "R1 reset outputs", {cmpPulse, demodPulse}, 0);
    rstN = 1'b1;
    enable = 1'b1;
    c0 = cyc;
    // R1: counting starts at the first edge after release, no clear
    pushRun(c0, 512, 64, 512, "R1");
    waitTo(c0 + 512);
    drain("R1");

    runCfg(5'b00001, 2, "R2");
    runCfg(5'b00010, 2, "R2");
    runCfg(5'b00100, 2, "R2");
    runCfg(5'b00111, 2, "R2");
    runCfg(5'b01000, 1, "R4");
    runCfg(5'b10000, 2, "R4");
    runCfg(5'b11000, 1, "R4");
    runCfg(5'b11111, 1, "R4");

    // R5: change selection mid-count, then restart under a new ratio
    @(negedge clk);
    c0 = cyc;
    rdSel = 5'b00011;
    pushRun(c0 + 1, ratioOf(5'b00011), 72, 300, "R5");
    waitTo(c0 + 301);
    runCfg(5'b00101, 2, "R5");

    // R6: drop enable mid-count; the schedule shifts by the disabled edges
    n = ratioOf(5'b00110);
    m = 30;
    h = 50;
    @(negedge clk);
    c0 = cyc;
    rdSel = 5'b00110;
    pushRun(c0 + 1 + h, n, 64, n, "R6");
    waitTo(c0 + 1 + m);
    enable = 1'b0;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      chk(!cmpPulse && !demodPulse, "R6 quiet while disabled", {cmpPulse, demodPulse}, 0);
    end
    enable = 1'b1;
    waitTo(c0 + 1 + h + n);
    drain("R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R1 watchdog expired", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule